// File: doc/BRIEF.md
# Prescaled Compare Timer with Watchdog Reset Request

This block is a 16-bit up-counter with two compare registers and a setup word, all reached through a four-word register port. A power-of-two prescaler sets how often the counter steps. Each of the two comparators is set on its own to be off, to match on equality, to match on greater-or-equal, or to run in event mode. In event mode a match also sends the counter back to zero. A match sets a sticky flag, and each flag drives an interrupt output. When the external watchdog arm input is high, the first match of comparator 2 produces a one-cycle reset request. Software re-arms the watchdog by writing the setup word, clearing the counter and loading compare 2 with the timeout.

Counting is governed by a run-state machine with three states. RS_OFF means the counter is disabled. RS_RUN means it counts. RS_FROZEN means it is held by the external halt input. The transitions are:
- OFF->RUN when the run bit is set and no hold is active.
- OFF->FROZEN when the run bit is set while a hold is active.
- RUN->FROZEN when the stop bit and halt_in are both high.
- FROZEN->RUN when that hold ends.
- RUN->OFF and FROZEN->OFF when the run bit is cleared.

The state register follows the setup word with one edge of latency.

Top module: `wdt_timer16`

## Requirements
- R1: Word select 0 is compare 1 (byte offset 0x0), 1 is compare 2 (0x2), 2 is the counter (0x4) and 3 is the setup word (0x6). Each reads back what was written. In setup, bit 15 is run, bit 11 is stop-on-halt, bits [9:8] are the compare-2 mode, bits [7:6] the compare-1 mode and bits [3:0] the prescaler. Bit 14 is flag 2 and bit 13 is flag 1. Bits 12, 10, 5 and 4 read as 0.
- R2: A synchronous reset (rst_n low at a rising edge) clears every register and flag and drives reset_req, irq_cmp1 and irq_cmp2 low.
- R3: With prescaler field d, the counter reads floor(k / 2^d) after k rising edges spent in RS_RUN, starting from a counter of 0 entered from RS_OFF.
- R4: The state machine follows the run bit one edge late. After the write that sets run, the first step with d=0 occurs on the second edge. After the write that clears run, the last step occurs on the edge following the write.
- R5: With stop set, the edge at which halt_in is first sampled high still steps the counter. Later edges do not step it while halt_in stays high. Stepping resumes on the second edge after halt_in falls. Without stop, halt_in has no effect.
- R6: On each step the comparator compares the counter value before the step with its compare register. Mode 01 sets its flag on equality, mode 10 on greater-or-equal, and mode 00 never sets it.
- R7: Mode 11 (event) sets the flag on equality and loads the counter with 0 instead of stepping it.
- R8: Flags are sticky, and irq_cmp1 and irq_cmp2 follow them. Writing 1 to bit 13 or 14 of setup clears that flag, and writing 0 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R9: A counter write takes priority over a step on the same edge. The counter wraps from 0xFFFF to 0x0000.
- R10: reset_req is high for exactly one cycle, starting at the edge where flag 2 goes from 0 to 1 while wd_arm is high. There is no pulse when wd_arm is low or when flag 2 was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Word select (byte offset = 2 x reg_sel) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected word (combinational) |
| halt_in | input | 1 | External halt, honoured when the stop bit is set |
| wd_arm | input | 1 | Enables the reset request on a compare-2 match |
| reset_req | output | 1 | Registered one-cycle reset request |
| irq_cmp1 | output | 1 | Compare-1 flag |
| irq_cmp2 | output | 1 | Compare-2 flag |

## Verification
Two events can fall on the same edge: a comparator setting its flag, and a software write of 1 that clears it. The bench provokes this by counting cycles from the run write so that the clearing setup write lands exactly on the matching step. It then expects the flag to read 1, and to read 0 only after a later clearing write with no match. A second same-edge case is a counter write that lands on a step edge. This is judged by reading back exactly the written value, followed by the wrap from 0xFFFF.

// File: rtl/wdt_timer_pkg.sv
package wdt_timer_pkg;

    localparam logic [1:0] SEL_CMP1  = 2'd0;
    localparam logic [1:0] SEL_CMP2  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_SETUP = 2'd3;

    localparam int B_RUN     = 15;
    localparam int B_FLAG2   = 14;
    localparam int B_FLAG1   = 13;
    localparam int B_STOP    = 11;
    localparam int B_MODE2   = 8;
    localparam int B_MODE1   = 6;
    localparam int NUM_CMP   = 2;

    typedef enum logic [1:0] {
        MATCH_OFF = 2'b00,
        MATCH_EQ  = 2'b01,
        MATCH_GE  = 2'b10,
        MATCH_EVT = 2'b11
    } match_mode_e;

    typedef enum logic [1:0] {
        RS_OFF    = 2'd0,
        RS_RUN    = 2'd1,
        RS_FROZEN = 2'd2
    } run_state_e;

endpackage

// File: rtl/wdt_runctl.sv
module wdt_runctl
    import wdt_timer_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             stop_en,
    input  logic             halt_in,
    input  logic [DIV_W-1:0] div_sel,
    output logic             step
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    run_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q, pre_d, mask;
    logic             hold;

    assign hold = stop_en & halt_in;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_OFF: begin
                if (run_en) state_d = hold ? RS_FROZEN : RS_RUN;
            end
            RS_RUN: begin
                if (!run_en)   state_d = RS_OFF;
                else if (hold) state_d = RS_FROZEN;
            end
            RS_FROZEN: begin
                if (!run_en)    state_d = RS_OFF;
                else if (!hold) state_d = RS_RUN;
            end
            default: state_d = RS_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_OFF;
            pre_q   <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
        end
    end

    // outputs: prescaler advance and step strobe
    always_comb begin
        mask  = ~({PRE_W{1'b1}} << div_sel);
        step  = 1'b0;
        pre_d = pre_q;
        unique case (state_q)
            RS_RUN: begin
                pre_d = pre_q + 1'b1;
                step  = ((pre_q & mask) == mask);
            end
            RS_FROZEN: pre_d = pre_q;
            RS_OFF:    pre_d = '0;
            default:   pre_d = '0;
        endcase
    end

endmodule

// File: rtl/wdt_match.sv
module wdt_match
    import wdt_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   mode_bits,
    input  logic         step,
    output logic         hit,
    output logic         restart
);
    match_mode_e mode;
    logic        eq, ge;

    always_comb begin
        mode    = match_mode_e'(mode_bits);
        eq      = (count == cmp);
        ge      = (count >= cmp);
        hit     = 1'b0;
        restart = 1'b0;
        unique case (mode)
            MATCH_OFF: hit = 1'b0;
            MATCH_EQ:  hit = step & eq;
            MATCH_GE:  hit = step & ge;
            MATCH_EVT: begin
                hit     = step & eq;
                restart = step & eq;
            end
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_timer16.sv
module wdt_timer16
    import wdt_timer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              halt_in,
    input  logic              wd_arm,
    output logic              reset_req,
    output logic              irq_cmp1,
    output logic              irq_cmp2
);
    logic [DATA_W-1:0] cmp_q [NUM_CMP];
    logic [DATA_W-1:0] count_q;
    logic              run_en_q, stop_en_q;
    logic [1:0]        mode_q [NUM_CMP];
    logic [DIV_W-1:0]  div_q;
    logic [NUM_CMP-1:0] flag_q, hit, restart, w1c;
    logic              step;
    logic              wr_cmp1, wr_cmp2, wr_count, wr_setup;
    logic              reset_req_q;
    logic [DATA_W-1:0] setup_word;

    assign wr_cmp1  = reg_wr & (reg_sel == SEL_CMP1);
    assign wr_cmp2  = reg_wr & (reg_sel == SEL_CMP2);
    assign wr_count = reg_wr & (reg_sel == SEL_COUNT);
    assign wr_setup = reg_wr & (reg_sel == SEL_SETUP);

    wdt_runctl #(.DIV_W(DIV_W)) u_runctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en_q),
        .stop_en (stop_en_q),
        .halt_in (halt_in),
        .div_sel (div_q),
        .step    (step)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        wdt_match #(.W(DATA_W)) u_match (
            .count     (count_q),
            .cmp       (cmp_q[g]),
            .mode_bits (mode_q[g]),
            .step      (step),
            .hit       (hit[g]),
            .restart   (restart[g])
        );
        assign w1c[g] = wr_setup & reg_wdata[B_FLAG1 + g];

        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= (flag_q[g] & ~w1c[g]) | hit[g];
        end
    end

    // configuration and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q[0]  <= '0;
            cmp_q[1]  <= '0;
            run_en_q  <= 1'b0;
            stop_en_q <= 1'b0;
            mode_q[0] <= 2'b00;
            mode_q[1] <= 2'b00;
            div_q     <= '0;
        end else begin
            if (wr_cmp1) cmp_q[0] <= reg_wdata;
            if (wr_cmp2) cmp_q[1] <= reg_wdata;
            if (wr_setup) begin
                run_en_q  <= reg_wdata[B_RUN];
                stop_en_q <= reg_wdata[B_STOP];
                mode_q[0] <= reg_wdata[B_MODE1 +: 2];
                mode_q[1] <= reg_wdata[B_MODE2 +: 2];
                div_q     <= reg_wdata[DIV_W-1:0];
            end
        end
    end

    // counter: write beats step, event match restarts at zero
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (wr_count)   count_q <= reg_wdata;
        else if (step)       count_q <= (|restart) ? '0 : count_q + 1'b1;
    end

    // reset request on the rising edge of flag 2 while armed
    always_ff @(posedge clk) begin
        if (!rst_n) reset_req_q <= 1'b0;
        else        reset_req_q <= wd_arm & hit[1] & ~flag_q[1];
    end

    always_comb begin
        setup_word                   = '0;
        setup_word[B_RUN]            = run_en_q;
        setup_word[B_FLAG2]          = flag_q[1];
        setup_word[B_FLAG1]          = flag_q[0];
        setup_word[B_STOP]           = stop_en_q;
        setup_word[B_MODE2 +: 2]     = mode_q[1];
        setup_word[B_MODE1 +: 2]     = mode_q[0];
        setup_word[DIV_W-1:0]        = div_q;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CMP1:  reg_rdata = cmp_q[0];
            SEL_CMP2:  reg_rdata = cmp_q[1];
            SEL_COUNT: reg_rdata = count_q;
            SEL_SETUP: reg_rdata = setup_word;
            default:   reg_rdata = '0;
        endcase
    end

    assign reset_req = reset_req_q;
    assign irq_cmp1  = flag_q[0];
    assign irq_cmp2  = flag_q[1];

endmodule

// File: rtl/wdt_timer16_chk.sv
module wdt_timer16_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              halt_in,
    input logic              wd_arm,
    input logic              reset_req,
    input logic              irq_cmp1,
    input logic              irq_cmp2,
    input logic [DATA_W-1:0] count_q,
    input logic              step,
    input logic              wr_count,
    input logic              run_en_q,
    input logic              stop_en_q
);
    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R10
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (irq_cmp2 && $past(wd_arm) && !$past(irq_cmp2)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_count) |=> $stable(count_q));

    // R8
    flag1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_cmp1) |-> $past(reg_wr && reg_sel == 2'd3 && reg_wdata[13]));

    // R8
    flag2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_cmp2) |-> $past(reg_wr && reg_sel == 2'd3 && reg_wdata[14]));

    // R5
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en_q && stop_en_q && halt_in) |-> !step);

    // R4
    off_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_en_q) |-> !step);

endmodule

bind wdt_timer16 wdt_timer16_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .halt_in   (halt_in),
    .wd_arm    (wd_arm),
    .reset_req (reset_req),
    .irq_cmp1  (irq_cmp1),
    .irq_cmp2  (irq_cmp2),
    .count_q   (count_q),
    .step      (step),
    .wr_count  (wr_count),
    .run_en_q  (run_en_q),
    .stop_en_q (stop_en_q)
);

// File: tb/sim_wdt_timer16.sv
`timescale 1ns/1ps
module sim_wdt_timer16;
    localparam logic [1:0] S_C1 = 2'd0, S_C2 = 2'd1, S_CNT = 2'd2, S_SET = 2'd3;
    localparam logic [15:0] EN = 16'h8000, STOP = 16'h0800;
    localparam logic [15:0] F1 = 16'h2000, F2 = 16'h4000;

    logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, halt_in = 1'b0, wd_arm = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0, reg_rdata;
    logic        reset_req, irq_cmp1, irq_cmp2;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    wdt_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halt_in(halt_in),
        .wd_arm(wd_arm), .reset_req(reset_req), .irq_cmp1(irq_cmp1), .irq_cmp2(irq_cmp2)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] r);
        reg_sel = s;
        #0.5;
        r = reg_rdata;
    endtask

    // stop, clear flags, zero counter, then run with the given setup
    task automatic start(input logic [15:0] setup);
        wr(S_SET, 16'h0);
        wr(S_SET, F1 | F2);
        wr(S_CNT, 16'h0);
        step(1);
        wr(S_SET, setup);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R2 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v); chk("R2 reg after reset", v, 16'h0);
        end
        chk("R2 outputs after reset", {13'h0, reset_req, irq_cmp1, irq_cmp2}, 16'h0);

        // R1 map and readback
        wr(S_C1, 16'h1234); wr(S_C2, 16'hABCD); wr(S_CNT, 16'h00A5);
        wr(S_SET, 16'h5FFF);
        rd(S_C1, v);  chk("R1 cmp1", v, 16'h1234);
        rd(S_C2, v);  chk("R1 cmp2", v, 16'hABCD);
        rd(S_CNT, v); chk("R1 count", v, 16'h00A5);
        rd(S_SET, v); chk("R1 setup", v, 16'h0BCF);
        wr(S_SET, 16'h0);
        wr(S_C1, 16'hFFFF); wr(S_C2, 16'hFFFF);

        // R3 prescaler sweep
        for (int d = 0; d < 5; d++) begin
            start(EN | 16'(d));
            for (int m = 1; m <= 40; m++) begin
                step(1);
                rd(S_CNT, v);
                chk($sformatf("R3 d=%0d m=%0d", d, m), v, 16'((m - 1) >> d));
            end
        end

        // R4 enable latency and disable
        start(EN);
        rd(S_CNT, v); chk("R4 no step at write", v, 16'd0);
        step(1); rd(S_CNT, v); chk("R4 first edge", v, 16'd0);
        step(1); rd(S_CNT, v); chk("R4 second edge", v, 16'd1);
        step(1); rd(S_CNT, v); chk("R4 before stop", v, 16'd2);
        wr(S_SET, 16'h0);
        rd(S_CNT, v); chk("R4 at disable", v, 16'd3);
        step(2); rd(S_CNT, v); chk("R4 last step", v, 16'd4);
        step(3); rd(S_CNT, v); chk("R4 stays off", v, 16'd4);

        // R5 stop on halt
        start(EN | STOP);
        step(5); rd(S_CNT, v); chk("R5 before halt", v, 16'd4);
        halt_in = 1'b1;
        step(1); rd(S_CNT, v); chk("R5 final step", v, 16'd5);
        step(4); rd(S_CNT, v); chk("R5 frozen", v, 16'd5);
        halt_in = 1'b0;
        step(1); rd(S_CNT, v); chk("R5 resume latency", v, 16'd5);
        step(1); rd(S_CNT, v); chk("R5 resumed", v, 16'd6);
        start(EN);
        halt_in = 1'b1;
        step(5); rd(S_CNT, v); chk("R5 halt ignored without stop", v, 16'd4);
        halt_in = 1'b0;

        // R6 equal mode on compare 1
        wr(S_SET, 16'h0); wr(S_C1, 16'd5);
        start(EN | 16'h0040);
        step(6); chk("R6 eq before match", {15'h0, irq_cmp1}, 16'd0);
        step(1); chk("R6 eq match", {15'h0, irq_cmp1}, 16'd1);
        rd(S_SET, v); chk("R6 flag1 bit 13", {15'h0, v[13]}, 16'd1);
        // R6 greater-or-equal on compare 2
        wr(S_SET, 16'h0); wr(S_C2, 16'd3);
        start(EN | 16'h0200);
        step(4); chk("R6 ge before", {15'h0, irq_cmp2}, 16'd0);
        step(1); chk("R6 ge match", {15'h0, irq_cmp2}, 16'd1);
        rd(S_SET, v); chk("R6 flag2 bit 14", {15'h0, v[14]}, 16'd1);
        // R6 off mode
        wr(S_SET, 16'h0); wr(S_C1, 16'd2);
        start(EN);
        step(10); chk("R6 off never sets", {14'h0, irq_cmp1, irq_cmp2}, 16'd0);

        // R7 event mode on both comparators
        wr(S_SET, 16'h0); wr(S_C1, 16'd4);
        start(EN | 16'h00C0);
        step(5); rd(S_CNT, v); chk("R7 at compare", v, 16'd4);
        step(1); rd(S_CNT, v); chk("R7 restart", v, 16'd0);
        chk("R7 flag1", {15'h0, irq_cmp1}, 16'd1);
        step(1); rd(S_CNT, v); chk("R7 after restart", v, 16'd1);
        wr(S_SET, 16'h0); wr(S_C2, 16'd2);
        start(EN | 16'h0300);
        step(3); rd(S_CNT, v); chk("R7 cmp2 at compare", v, 16'd2);
        step(1); rd(S_CNT, v); chk("R7 cmp2 restart", v, 16'd0);
        chk("R7 flag2", {15'h0, irq_cmp2}, 16'd1);

        // R8 clear colliding with a match
        wr(S_SET, 16'h0); wr(S_C1, 16'd5);
        start(EN | 16'h0040);
        step(6);
        wr(S_SET, EN | 16'h0040 | F1);
        chk("R8 set wins over clear", {15'h0, irq_cmp1}, 16'd1);
        wr(S_SET, EN | 16'h0040);
        chk("R8 write 0 keeps flag", {15'h0, irq_cmp1}, 16'd1);
        wr(S_SET, EN | 16'h0040 | F1);
        chk("R8 write 1 clears", {15'h0, irq_cmp1}, 16'd0);

        // R9 counter write beats step and wraps
        start(EN);
        step(2);
        wr(S_CNT, 16'hFFFE);
        rd(S_CNT, v); chk("R9 write wins", v, 16'hFFFE);
        step(1); rd(S_CNT, v); chk("R9 top", v, 16'hFFFF);
        step(1); rd(S_CNT, v); chk("R9 wrap", v, 16'h0000);

        // R10 reset request, equal mode armed
        wr(S_SET, 16'h0); wr(S_C2, 16'd6);
        wd_arm = 1'b1;
        start(EN | 16'h0100);
        pulses = 0;
        for (int m = 1; m <= 12; m++) begin
            step(1);
            chk($sformatf("R10 pulse m=%0d", m), {15'h0, reset_req}, (m == 8) ? 16'd1 : 16'd0);
            if (reset_req) pulses++;
        end
        chk("R10 flag2 set", {15'h0, irq_cmp2}, 16'd1);
        // R10 greater-or-equal keeps matching: one pulse only
        start(EN | 16'h0200);
        pulses = 0;
        for (int m = 1; m <= 20; m++) begin
            step(1);
            if (reset_req) pulses++;
        end
        chk("R10 single pulse in ge", 16'(pulses), 16'd1);
        // R10 disarmed: flag but no pulse
        wd_arm = 1'b0;
        start(EN | 16'h0100);
        pulses = 0;
        for (int m = 1; m <= 12; m++) begin
            step(1);
            if (reset_req) pulses++;
        end
        chk("R10 no pulse disarmed", 16'(pulses), 16'd0);
        chk("R10 flag2 disarmed", {15'h0, irq_cmp2}, 16'd1);

        // R2 synchronous reset mid-run
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        rd(S_SET, v); chk("R2 setup after reset", v, 16'h0);
        rd(S_CNT, v); chk("R2 count after reset", v, 16'h0);
        chk("R2 flags after reset", {14'h0, irq_cmp1, irq_cmp2}, 16'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule